// File: doc/BRIEF.md
# Response Return Crossbar with Transaction-End Detection

This block carries the two slave-to-master channels of a four-by-four bus interconnect: read data (with ID, response code and last-beat flag) and write response (with ID and response code). Each slave's arbiter holds a one-hot grant naming the master that currently owns that slave, with a separate grant for reads and for writes. The crossbar uses those grants to send each slave's return traffic to its owning master. It gates every field with AND/OR logic, so any master without a grant sees all zeros. It also sends each master's ready signal back only to the slave that master owns.

The block tells each slave's arbiter when the current transaction is finished, so that the grant can be released. A read ends on the handshake of the beat that carries the last-beat flag. A write ends on the handshake of the write response. Each of these events raises a one-cycle pulse on an output indexed by slave number. The routing is purely combinational. The end pulses are registered.

Top module: `resp_return_xbar`

## Requirements
- R1: A slave's read grant is a 4-bit one-hot vector. Bit 3 names master 0, bit 2 master 1, bit 1 master 2 and bit 0 master 3, so 4'b1000 means master 0. Within the same cycle, the named master receives that slave's read data, ID, response, last flag and valid unchanged.
- R2: A master that no slave's read grant names sees zero on its read data, ID, response, last and valid outputs, whatever the slaves drive.
- R3: A master that no slave's write grant names sees zero on its write-response ID, response and valid outputs.
- R4: The write grant uses the same bit order as R1. The named master receives the slave's write-response ID, valid and 2-bit response unchanged, for each of the codes 00 OKAY, 01 EXOKAY, 10 SLVERR and 11 DECERR.
- R5: A slave's read ready output equals the read ready input of the master its read grant names. It is low when the grant is zero, and no other master's ready affects it.
- R6: A slave's write-response ready output equals the write-response ready input of the master its write grant names. It is low when the grant is zero.
- R7: The read end output for slave s is high for exactly one cycle, in the cycle after a cycle in which that slave's read valid, read last and forwarded read ready are all high. A beat without the last flag, or a last beat stalled by a low ready, raises no pulse.
- R8: The write end output for slave s is high for exactly one cycle, in the cycle after a cycle in which that slave's write-response valid and forwarded ready are both high. A valid response with no grant raises no pulse.
- R9: While reset is asserted, and in the first cycle after it, both end outputs are all zero.
- R10: Different slaves granted to different masters return traffic at the same time, each on its own path, without interference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_sel_i | input | 4x4 | Per-slave one-hot read grant (bit 3 = master 0) |
| wr_sel_i | input | 4x4 | Per-slave one-hot write grant (bit 3 = master 0) |
| s_rdata_i | input | 4x64 | Slave read data |
| s_rid_i | input | 4x4 | Slave read ID |
| s_rresp_i | input | 4x2 | Slave read response |
| s_rlast_i | input | 4 | Slave last read beat |
| s_rvalid_i | input | 4 | Slave read valid |
| s_rready_o | output | 4 | Read ready steered to each slave |
| s_bid_i | input | 4x4 | Slave write-response ID |
| s_bresp_i | input | 4x2 | Slave write response |
| s_bvalid_i | input | 4 | Slave write-response valid |
| s_bready_o | output | 4 | Write-response ready steered to each slave |
| m_rdata_o | output | 4x64 | Read data per master |
| m_rid_o | output | 4x4 | Read ID per master |
| m_rresp_o | output | 4x2 | Read response per master |
| m_rlast_o | output | 4 | Last read beat per master |
| m_rvalid_o | output | 4 | Read valid per master |
| m_rready_i | input | 4 | Master read ready |
| m_bid_o | output | 4x4 | Write-response ID per master |
| m_bresp_o | output | 4x2 | Write response per master |
| m_bvalid_o | output | 4 | Write-response valid per master |
| m_bready_i | input | 4 | Master write-response ready |
| r_end_o | output | 4 | Read transaction end pulse per slave |
| w_end_o | output | 4 | Write transaction end pulse per slave |

## Verification
The routing holds no state. A wrong grant decode therefore shows on the master outputs in the same cycle: payload leaks to an idle master, or the owning master sees zeros. A misrouted ready shows in the same cycle on the slave ready outputs.

The only state is the end-pulse registers. A fault there shows one cycle after the handshake in one of three ways: a pulse is missing, a pulse appears on a non-last or stalled beat, or more than one pulse appears per burst. Each of these would leave the arbiter's grant stuck or release it early.

// File: rtl/resp_xbar_pkg.sv
`timescale 1ns/1ps
package resp_xbar_pkg;
  localparam int RESP_W = 2;

  typedef enum logic [RESP_W-1:0] {
    RESP_OKAY   = 2'b00,
    RESP_EXOKAY = 2'b01,
    RESP_SLVERR = 2'b10,
    RESP_DECERR = 2'b11
  } resp_e;
endpackage

// File: rtl/ret_or_mux.sv
`timescale 1ns/1ps
// AND/OR gather: sources whose hit bit is low contribute zero
module ret_or_mux #(
  parameter int N_SRC = 4,
  parameter int W     = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_SRC-1:0]         hit_i,
  input  logic [N_SRC-1:0][W-1:0]  src_i,
  output logic [W-1:0]             out_o
);
  always_comb begin
    out_o = '0;
    for (int i = 0; i < N_SRC; i++) out_o |= src_i[i] & {W{hit_i[i]}};
  end

  // one outstanding transaction: a master owns at most one slave per channel
  p_single_owner_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_i));
endmodule

// File: rtl/ret_ready_steer.sv
`timescale 1ns/1ps
// returns the owning master's ready to one slave; sel bit N_MST-1 = master 0
module ret_ready_steer #(
  parameter int N_MST = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MST-1:0] sel_i,
  input  logic [N_MST-1:0] rdy_i,
  output logic             rdy_o
);
  always_comb begin
    rdy_o = 1'b0;
    for (int m = 0; m < N_MST; m++) rdy_o |= sel_i[N_MST-1-m] & rdy_i[m];
  end

  p_grant_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_i));
  p_no_grant_no_ready_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == '0) |-> !rdy_o);
endmodule

// File: rtl/ret_end_pulse.sv
`timescale 1ns/1ps
module ret_end_pulse (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic ready_i,
  input  logic last_i,
  output logic end_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) end_o <= 1'b0;
    else         end_o <= valid_i & ready_i & last_i;
  end
endmodule

// File: rtl/resp_return_xbar.sv
`timescale 1ns/1ps
module resp_return_xbar
  import resp_xbar_pkg::*;
#(
  parameter int N_MST  = 4,
  parameter int N_SLV  = 4,
  parameter int DATA_W = 64,
  parameter int ID_W   = 4
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [N_SLV-1:0][N_MST-1:0]         rd_sel_i,
  input  logic [N_SLV-1:0][N_MST-1:0]         wr_sel_i,
  input  logic [N_SLV-1:0][DATA_W-1:0]        s_rdata_i,
  input  logic [N_SLV-1:0][ID_W-1:0]          s_rid_i,
  input  logic [N_SLV-1:0][RESP_W-1:0]        s_rresp_i,
  input  logic [N_SLV-1:0]                    s_rlast_i,
  input  logic [N_SLV-1:0]                    s_rvalid_i,
  output logic [N_SLV-1:0]                    s_rready_o,
  input  logic [N_SLV-1:0][ID_W-1:0]          s_bid_i,
  input  logic [N_SLV-1:0][RESP_W-1:0]        s_bresp_i,
  input  logic [N_SLV-1:0]                    s_bvalid_i,
  output logic [N_SLV-1:0]                    s_bready_o,
  output logic [N_MST-1:0][DATA_W-1:0]        m_rdata_o,
  output logic [N_MST-1:0][ID_W-1:0]          m_rid_o,
  output logic [N_MST-1:0][RESP_W-1:0]        m_rresp_o,
  output logic [N_MST-1:0]                    m_rlast_o,
  output logic [N_MST-1:0]                    m_rvalid_o,
  input  logic [N_MST-1:0]                    m_rready_i,
  output logic [N_MST-1:0][ID_W-1:0]          m_bid_o,
  output logic [N_MST-1:0][RESP_W-1:0]        m_bresp_o,
  output logic [N_MST-1:0]                    m_bvalid_o,
  input  logic [N_MST-1:0]                    m_bready_i,
  output logic [N_SLV-1:0]                    r_end_o,
  output logic [N_SLV-1:0]                    w_end_o
);
  localparam int RD_W = DATA_W + ID_W + RESP_W + 2;
  localparam int WR_W = ID_W + RESP_W + 1;

  logic [N_SLV-1:0][RD_W-1:0] rd_pl;
  logic [N_SLV-1:0][WR_W-1:0] wr_pl;

  for (genvar s = 0; s < N_SLV; s++) begin : g_slv
    assign rd_pl[s] = {s_rdata_i[s], s_rid_i[s], s_rresp_i[s], s_rlast_i[s], s_rvalid_i[s]};
    assign wr_pl[s] = {s_bid_i[s], s_bresp_i[s], s_bvalid_i[s]};

    ret_ready_steer #(.N_MST(N_MST)) u_rrdy (
      .clk_i, .rst_ni, .sel_i(rd_sel_i[s]), .rdy_i(m_rready_i), .rdy_o(s_rready_o[s]));
    ret_ready_steer #(.N_MST(N_MST)) u_brdy (
      .clk_i, .rst_ni, .sel_i(wr_sel_i[s]), .rdy_i(m_bready_i), .rdy_o(s_bready_o[s]));

    ret_end_pulse u_rend (
      .clk_i, .rst_ni, .valid_i(s_rvalid_i[s]), .ready_i(s_rready_o[s]),
      .last_i(s_rlast_i[s]), .end_o(r_end_o[s]));
    ret_end_pulse u_wend (
      .clk_i, .rst_ni, .valid_i(s_bvalid_i[s]), .ready_i(s_bready_o[s]),
      .last_i(1'b1), .end_o(w_end_o[s]));

    p_rend_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      r_end_o[s] |-> $past(s_rvalid_i[s] && s_rlast_i[s] && s_rready_o[s]));
    p_wend_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      w_end_o[s] |-> $past(s_bvalid_i[s] && s_bready_o[s]));
  end

  for (genvar m = 0; m < N_MST; m++) begin : g_mst
    logic [N_SLV-1:0] rd_hit, wr_hit;
    logic [RD_W-1:0]  rd_out;
    logic [WR_W-1:0]  wr_out;

    for (genvar s = 0; s < N_SLV; s++) begin : g_hit
      assign rd_hit[s] = rd_sel_i[s][N_MST-1-m];
      assign wr_hit[s] = wr_sel_i[s][N_MST-1-m];
    end

    ret_or_mux #(.N_SRC(N_SLV), .W(RD_W)) u_rmux (
      .clk_i, .rst_ni, .hit_i(rd_hit), .src_i(rd_pl), .out_o(rd_out));
    ret_or_mux #(.N_SRC(N_SLV), .W(WR_W)) u_bmux (
      .clk_i, .rst_ni, .hit_i(wr_hit), .src_i(wr_pl), .out_o(wr_out));

    assign {m_rdata_o[m], m_rid_o[m], m_rresp_o[m], m_rlast_o[m], m_rvalid_o[m]} = rd_out;
    assign {m_bid_o[m], m_bresp_o[m], m_bvalid_o[m]} = wr_out;

    p_rd_idle_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_hit == '0) |-> (!m_rvalid_o[m] && m_rdata_o[m] == '0 && !m_rlast_o[m]));
    p_wr_idle_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_hit == '0) |-> (!m_bvalid_o[m] && m_bresp_o[m] == '0));
  end
endmodule

// File: tb/resp_return_xbar_tb.sv
`timescale 1ns/1ps
module resp_return_xbar_tb;
  import resp_xbar_pkg::*;
  localparam int NM = 4, NS = 4, DW = 64, IW = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic [NS-1:0][NM-1:0] rd_sel, wr_sel;
  logic [NS-1:0][DW-1:0] s_rdata;
  logic [NS-1:0][IW-1:0] s_rid, s_bid;
  logic [NS-1:0][1:0]    s_rresp, s_bresp;
  logic [NS-1:0]         s_rlast, s_rvalid, s_rready, s_bvalid, s_bready;
  logic [NM-1:0][DW-1:0] m_rdata;
  logic [NM-1:0][IW-1:0] m_rid, m_bid;
  logic [NM-1:0][1:0]    m_rresp, m_bresp;
  logic [NM-1:0]         m_rlast, m_rvalid, m_rready, m_bvalid, m_bready;
  logic [NS-1:0]         r_end, w_end;

  resp_return_xbar u_dut (
    .clk_i(clk), .rst_ni, .rd_sel_i(rd_sel), .wr_sel_i(wr_sel),
    .s_rdata_i(s_rdata), .s_rid_i(s_rid), .s_rresp_i(s_rresp), .s_rlast_i(s_rlast),
    .s_rvalid_i(s_rvalid), .s_rready_o(s_rready), .s_bid_i(s_bid), .s_bresp_i(s_bresp),
    .s_bvalid_i(s_bvalid), .s_bready_o(s_bready), .m_rdata_o(m_rdata), .m_rid_o(m_rid),
    .m_rresp_o(m_rresp), .m_rlast_o(m_rlast), .m_rvalid_o(m_rvalid), .m_rready_i(m_rready),
    .m_bid_o(m_bid), .m_bresp_o(m_bresp), .m_bvalid_o(m_bvalid), .m_bready_i(m_bready),
    .r_end_o(r_end), .w_end_o(w_end));

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NM-1:0] grant(input int m);
    return NM'(1) << (NM-1-m);
  endfunction

  task automatic idle_inputs();
    rd_sel = '0; wr_sel = '0; s_rlast = '0; s_rvalid = '0; s_bvalid = '0;
    m_rready = '0; m_bready = '0;
    for (int s = 0; s < NS; s++) begin
      s_rdata[s] = {$urandom, $urandom}; s_rid[s] = IW'(s + 5);
      s_rresp[s] = 2'(s); s_bid[s] = IW'(s + 9); s_bresp[s] = 2'(3 - s);
    end
  endtask

  // read-side expectation for master m fed from slave s (s<0: idle)
  task automatic chk_rd(input int m, input int s, input string req);
    logic [DW+IW+4-1:0] exp, act;
    act = {m_rdata[m], m_rid[m], m_rresp[m], m_rlast[m], m_rvalid[m]};
    exp = (s < 0) ? '0 : {s_rdata[s], s_rid[s], s_rresp[s], s_rlast[s], s_rvalid[s]};
    chk(act == exp, req, 128'(act), 128'(exp));
  endtask

  task automatic chk_wr(input int m, input int s, input string req);
    logic [IW+3-1:0] exp, act;
    act = {m_bid[m], m_bresp[m], m_bvalid[m]};
    exp = (s < 0) ? '0 : {s_bid[s], s_bresp[s], s_bvalid[s]};
    chk(act == exp, req, 128'(act), 128'(exp));
  endtask

  task automatic t_reset();
    idle_inputs();
    s_rvalid = '1; s_rlast = '1; s_bvalid = '1; m_rready = '1; m_bready = '1;
    repeat (3) @(negedge clk);
    chk(r_end == '0 && w_end == '0, "R9 ends low in reset", 128'({r_end, w_end}), 0);
    for (int m = 0; m < NM; m++) begin
      chk_rd(m, -1, "R2 no grant read zero");
      chk_wr(m, -1, "R3 no grant write zero");
    end
    chk(s_rready == '0 && s_bready == '0, "R5 R6 no grant ready low",
        128'({s_rready, s_bready}), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(r_end == '0 && w_end == '0, "R9 ends low after release", 128'({r_end, w_end}), 0);
    idle_inputs();
    @(negedge clk);
  endtask

  task automatic t_route_each();
    idle_inputs();
    rd_sel[0] = 4'b1000;  // encoding check: bit 3 selects master 0
    s_rvalid[0] = 1'b1; s_rlast[0] = 1'b1;
    #1 chk_rd(0, 0, "R1 4'b1000 to master 0");
    for (int s = 0; s < NS; s++)
      for (int m = 0; m < NM; m++) begin
        idle_inputs();
        rd_sel[s] = grant(m); s_rvalid = '1; s_rlast[s] = 1'($urandom);
        #1;
        for (int k = 0; k < NM; k++)
          if (k == m) chk_rd(k, s, "R1 read routed");
          else        chk_rd(k, -1, "R2 unselected read zero");
      end
    idle_inputs();
    #1;
  endtask

  task automatic t_ready_steer();
    for (int s = 0; s < NS; s++)
      for (int m = 0; m < NM; m++) begin
        idle_inputs();
        rd_sel[s] = grant(m); wr_sel[s] = grant(m);
        for (int k = 0; k < NM; k++) begin
          m_rready = NM'(1) << k; m_bready = NM'(1) << k;
          #1;
          chk(s_rready[s] == (k == m), "R5 rready steered", 128'(s_rready), 128'(k == m));
          chk(s_bready[s] == (k == m), "R6 bready steered", 128'(s_bready), 128'(k == m));
        end
      end
    idle_inputs();
    m_rready = '1; m_bready = '1;
    #1 chk(s_rready == '0 && s_bready == '0, "R5 R6 all ready but no grant",
           128'({s_rready, s_bready}), 0);
    idle_inputs();
    #1;
  endtask

  task automatic t_bresp_codes();
    for (int c = 0; c < 4; c++) begin
      idle_inputs();
      wr_sel[2] = grant(1); s_bvalid = '1; s_bresp[2] = 2'(c);
      #1;
      chk(m_bresp[1] == 2'(c), "R4 bresp code passed", 128'(m_bresp[1]), 128'(c));
      chk_wr(1, 2, "R4 write response routed");
      for (int k = 0; k < NM; k++) if (k != 1) chk_wr(k, -1, "R3 unselected write zero");
    end
    idle_inputs();
    #1;
  endtask

  task automatic t_parallel();
    int perm[NS] = '{2, 0, 3, 1};
    idle_inputs();
    for (int s = 0; s < NS; s++) begin
      rd_sel[s] = grant(perm[s]); wr_sel[perm[s] % NS] = grant(s);
    end
    s_rvalid = '1; s_bvalid = '1; s_rlast = 4'b1010;
    #1;
    for (int s = 0; s < NS; s++) chk_rd(perm[s], s, "R10 parallel read path");
    for (int s = 0; s < NS; s++) chk_wr(s, perm[s] % NS, "R10 parallel write path");
    idle_inputs();
    #1;
  endtask

  // burst of len beats from slave s to master m with random stalls
  task automatic t_read_burst(input int s, input int m, input int len);
    int beat = 0, pulses = 0;
    bit pend = 0;
    idle_inputs();
    while (beat < len) begin
      @(negedge clk);
      chk(r_end[s] == pend, "R7 read end timing", 128'(r_end[s]), 128'(pend));
      for (int k = 0; k < NS; k++)
        if (k != s && r_end[k]) chk(0, "R7 end on wrong slave", 128'(r_end), 0);
      if (r_end[s]) pulses++;
      rd_sel[s] = grant(m);
      s_rvalid[s] = ($urandom % 4) != 0;
      s_rlast[s] = (beat == len - 1);
      s_rdata[s] = {$urandom, $urandom};
      m_rready = NM'($urandom);
      #1;
      chk_rd(m, s, "R1 burst beat routed");
      chk_rd((m + 1) % NM, -1, "R2 no leak during burst");
      chk(s_rready[s] == m_rready[m], "R5 burst ready", 128'(s_rready[s]), 128'(m_rready[m]));
      pend = s_rvalid[s] && m_rready[m] && s_rlast[s];
      if (s_rvalid[s] && m_rready[m]) beat++;
    end
    @(negedge clk);
    chk(r_end[s] == pend, "R7 read end after last", 128'(r_end[s]), 128'(pend));
    if (r_end[s]) pulses++;
    idle_inputs();
    @(negedge clk);
    chk(r_end == '0, "R7 single-cycle pulse", 128'(r_end), 0);
    chk(pulses == 1, "R7 one end per burst", 128'(pulses), 1);
  endtask

  task automatic t_write_resp(input int s, input int m);
    int pulses = 0;
    bit done = 0, pend = 0;
    idle_inputs();
    // valid response but no grant: no end pulse
    s_bvalid[s] = 1'b1; m_bready = '1;
    @(negedge clk);
    chk(w_end == '0, "R8 no grant no end", 128'(w_end), 0);
    while (!done) begin
      wr_sel[s] = grant(m);
      s_bvalid[s] = 1'b1;
      m_bready = NM'($urandom);
      #1 chk_wr(m, s, "R4 response routed");
      pend = m_bready[m];
      done = pend;
      @(negedge clk);
      chk(w_end[s] == pend, "R8 write end timing", 128'(w_end[s]), 128'(pend));
      if (w_end[s]) pulses++;
    end
    idle_inputs();
    @(negedge clk);
    chk(w_end == '0, "R8 single-cycle pulse", 128'(w_end), 0);
    chk(pulses == 1, "R8 one end per response", 128'(pulses), 1);
  endtask

  initial begin
    #2000000;
    chk(0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    t_reset();
    t_route_each();
    t_ready_steer();
    t_bresp_codes();
    t_parallel();
    t_read_burst(0, 0, 1);
    t_read_burst(3, 2, 8);
    for (int i = 0; i < 12; i++)
      t_read_burst(int'($urandom % NS), int'($urandom % NM), 1 + int'($urandom % 8));
    for (int i = 0; i < 8; i++)
      t_write_resp(int'($urandom % NS), int'($urandom % NM));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule